// File: doc/BRIEF.md
# Identification-Page Lock Controller for a Serial Memory Slave

This block is the slave-side control logic of a serial memory port. It handles two operations on the identification page: a status read that reports whether the page is locked, and a one-time command that locks the page for good. It also handles the write-enable instruction that arms the lock command. Chip select, serial clock and serial data in are sampled with the system clock through synchronisers. Serial data out is driven on the falling serial clock edge, using clock polarity 0 and phase 0.

A lock request is honoured only when all of these hold: the page is armed, the right address bit is set, the right data bit is set, and chip select rises exactly after the last data bit. An honoured request starts a self-timed write cycle whose length is counted in system clocks. When that cycle ends, the lock flag is set and stays set until power-on reset. While the cycle runs, every transaction is ignored.

Top module: `idpage_lock`

## Requirements
- R1: After reset `locked_o`, `wel_o`, `busy_o` and `miso_oe_o` are all 0.
- R2: Opcode `OP_WREN` (default 0x06) sets `wel_o` only when chip select rises after exactly 8 bits. A frame of 7 or 9 bits leaves `wel_o` at 0.
- R3: Opcode `OP_RDLS` (default 0x83) is followed by a 16-bit address sent MSB first. When address bit 10 is 1, the device returns a status byte from the 25th clock onward, MSB first. The status byte is 0x01 when locked and 0x00 when unlocked, and it repeats for as long as chip select stays low. `miso_o` changes after the falling serial clock edge and is valid at the next rising edge.
- R4: A status read with address bit 10 at 0 returns 0 on every bit.
- R5: `miso_oe_o` is 0 whenever chip select is high (after a two-clock synchroniser delay) and 1 while it is low.
- R6: Opcode `OP_LOCK` (default 0x82) starts the write cycle (`busy_o`=1) only if all of the following hold: `wel_o` is 1, address bit 10 is 1, bit 1 of the data byte (the 4th byte) is 1, the page is not yet locked, and chip select rises after exactly 32 bits.
- R7: A lock frame that fails any condition of R6 is dropped, and it clears `wel_o`. A cut-off of 28 to 31 bits or of 33 to 40 bits counts as a failure.
- R8: The write cycle lasts `TW_CYCLES` system clocks. As `busy_o` falls, `locked_o` becomes 1 and `wel_o` becomes 0.
- R9: A transaction that begins while `busy_o` is 1 has no effect. It does not change `wel_o` and it returns no status bits.
- R10: Once `locked_o` is 1, no command clears it. Only reset does.
- R11: All address bits except bit 10 are ignored, and all data bits except bit 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for `miso_o`; the pad is high impedance when 0 |
| wel_o | output | 1 | Write-enable latch |
| busy_o | output | 1 | Self-timed write cycle in progress |
| locked_o | output | 1 | Identification page lock flag |

## Verification
The assertions assume the following about the inputs:
- Chip select is held high through reset.
- Each level of the serial clock lasts at least three system clocks.
- Serial data is stable around every rising edge of the serial clock.

Under these conditions, the synchronised edges arrive in the same order as the pin edges. The stimulus keeps to this by using half-periods of four system clocks on the serial clock. It changes data only while the serial clock is low, and it holds chip select high during every reset. It also leaves several clocks between the last falling edge and the rise of chip select.

// File: rtl/idlk_pkg.sv
package idlk_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned BYTE_CNT_W = 3;
  // byte index just completed -> field captured
  localparam logic [BYTE_CNT_W-1:0] BYTE_OP     = 3'd0;
  localparam logic [BYTE_CNT_W-1:0] BYTE_ADR_HI = 3'd1;
  localparam logic [BYTE_CNT_W-1:0] BYTE_DATA   = 3'd3;
  // byte counts seen at chip-select rise
  localparam logic [BYTE_CNT_W-1:0] CNT_WREN    = 3'd1;
  localparam logic [BYTE_CNT_W-1:0] CNT_RD_OUT  = 3'd3;
  localparam logic [BYTE_CNT_W-1:0] CNT_LOCK    = 3'd4;
  localparam logic [BYTE_CNT_W-1:0] CNT_SAT     = 3'd5;
  localparam int unsigned A10_IN_HI  = 2;
  localparam int unsigned LOCK_DBIT  = 1;
endpackage

// File: rtl/idlk_sync.sv
module idlk_sync #(
  parameter int unsigned N = 3,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= INIT[g];
        s2 <= INIT[g];
        s3 <= INIT[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q_o[g]    = s2;
    assign rise_o[g] = s2 & ~s3;
    assign fall_o[g] = ~s2 & s3;
  end
endmodule

// File: rtl/idlk_frame.sv
module idlk_frame
  import idlk_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  active_i,
  input  logic                  sck_rise_i,
  input  logic                  mosi_i,
  output byte_t                 op_o,
  output logic                  a10_o,
  output logic                  d1_o,
  output logic [BYTE_CNT_W-1:0] byte_cnt_o,
  output logic [2:0]            bit_cnt_o
);
  byte_t sh_q;
  byte_t sh_nxt;
  assign sh_nxt = {sh_q[6:0], mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      op_o       <= '0;
      a10_o      <= 1'b0;
      d1_o       <= 1'b0;
      byte_cnt_o <= '0;
      bit_cnt_o  <= '0;
    end else if (start_i) begin
      sh_q       <= '0;
      op_o       <= '0;
      a10_o      <= 1'b0;
      d1_o       <= 1'b0;
      byte_cnt_o <= '0;
      bit_cnt_o  <= '0;
    end else if (active_i && sck_rise_i) begin
      sh_q      <= sh_nxt;
      bit_cnt_o <= bit_cnt_o + 3'd1;
      if (bit_cnt_o == 3'd7) begin
        if (byte_cnt_o != CNT_SAT) byte_cnt_o <= byte_cnt_o + 1'b1;
        unique case (byte_cnt_o)
          BYTE_OP:     op_o  <= sh_nxt;
          BYTE_ADR_HI: a10_o <= sh_nxt[A10_IN_HI];
          BYTE_DATA:   d1_o  <= sh_nxt[LOCK_DBIT];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idlk_timer.sv
module idlk_timer #(
  parameter int unsigned TW_CYCLES = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(TW_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(TW_CYCLES - 1);
  logic [CW-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/idpage_lock.sv
module idpage_lock
  import idlk_pkg::*;
#(
  parameter byte_t       OP_WREN   = 8'h06,
  parameter byte_t       OP_RDLS   = 8'h83,
  parameter byte_t       OP_LOCK   = 8'h82,
  parameter int unsigned TW_CYCLES = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o,
  output logic wel_o,
  output logic busy_o,
  output logic locked_o
);
  logic [2:0] pin_q, pin_rise, pin_fall;
  logic cs_q, cs_start, cs_end, sck_rise, sck_fall, mosi_q;

  idlk_sync #(.N(3), .INIT(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cs_ni, sck_i, mosi_i}),
    .q_o(pin_q), .rise_o(pin_rise), .fall_o(pin_fall)
  );
  assign cs_q     = pin_q[2];
  assign cs_start = pin_fall[2];
  assign cs_end   = pin_rise[2];
  assign sck_rise = pin_rise[1];
  assign sck_fall = pin_fall[1];
  assign mosi_q   = pin_q[0];

  byte_t                 op;
  logic                  a10, d1;
  logic [BYTE_CNT_W-1:0] byte_cnt;
  logic [2:0]            bit_cnt;

  idlk_frame u_frame (
    .clk_i, .rst_ni,
    .start_i(cs_start), .active_i(!cs_q), .sck_rise_i(sck_rise), .mosi_i(mosi_q),
    .op_o(op), .a10_o(a10), .d1_o(d1), .byte_cnt_o(byte_cnt), .bit_cnt_o(bit_cnt)
  );

  logic lock_go, wt_done;
  idlk_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(lock_go), .busy_o(busy_o), .done_o(wt_done)
  );

  logic txn_ok, miso_q;
  logic rd_active, at_byte_edge, lock_drop, wren_go;
  byte_t status;

  assign status       = {7'b0, locked_o};
  assign at_byte_edge = (bit_cnt == 3'd0);
  assign rd_active    = txn_ok && (op == OP_RDLS) && a10 && (byte_cnt >= CNT_RD_OUT);
  assign wren_go      = cs_end && txn_ok && (op == OP_WREN) &&
                        (byte_cnt == CNT_WREN) && at_byte_edge;
  assign lock_go      = cs_end && txn_ok && (op == OP_LOCK) && wel_o && a10 && d1 &&
                        !locked_o && (byte_cnt == CNT_LOCK) && at_byte_edge;
  assign lock_drop    = cs_end && txn_ok && (op == OP_LOCK) && !lock_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txn_ok   <= 1'b0;
      miso_q   <= 1'b0;
      wel_o    <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      if (cs_start) txn_ok <= !busy_o;
      else if (cs_end) txn_ok <= 1'b0;

      if (cs_start) miso_q <= 1'b0;
      else if (sck_fall && !cs_q) miso_q <= rd_active ? status[~bit_cnt] : 1'b0;

      if (wt_done || lock_drop) wel_o <= 1'b0;
      else if (wren_go) wel_o <= 1'b1;

      if (wt_done) locked_o <= 1'b1;
    end
  end

  assign miso_o    = miso_q;
  assign miso_oe_o = !cs_q;
endmodule

// File: rtl/idlk_checker.sv
module idlk_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic miso_oe_o,
  input logic wel_o,
  input logic busy_o,
  input logic locked_o
);
  assert_hiz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni, 2) |-> !miso_oe_o);
  assert_arm_needed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(wel_o) && !$past(locked_o)));
  assert_lock_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $fell(busy_o));
  assert_wel_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !wel_o);
  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !$rose(wel_o));
  assert_lock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
endmodule

bind idpage_lock idlk_checker u_chk (.*);

// File: tb/idpage_lock_test.sv
module idpage_lock_test;
  localparam int TW = 1500;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso_o, miso_oe_o, wel_o, busy_o, locked_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  idpage_lock #(.TW_CYCLES(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .wel_o(wel_o), .busy_o(busy_o),
    .locked_o(locked_o)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cs_ni = 1'b1; sck = 1'b0; mosi = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [39:0] tx, input int n, output logic [39:0] rx,
                      output logic oe_ok);
    rx = '0; oe_ok = 1'b1;
    @(negedge clk); cs_ni = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      mosi = tx[39-k];
      repeat (4) @(negedge clk);
      rx[39-k] = miso_o;
      if (miso_oe_o !== 1'b1) oe_ok = 1'b0;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_ni = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [39:0] rd_exp(input logic lk, input logic a10, input int n);
    logic [39:0] e = '0;
    for (int k = 24; k < n; k++) e[39-k] = a10 && (k % 8 == 7) && lk;
    return e;
  endfunction

  task automatic send_wren();
    logic [39:0] rx; logic oe;
    xfer({8'h06, 32'h0}, 8, rx, oe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] rx;
    logic oe;
    do_reset();
    chk("R1 locked", locked_o, 0);
    chk("R1 wel", wel_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 oe", miso_oe_o, 0);

    // R2: write-enable frame length sweep
    for (int n = 7; n <= 9; n++) begin
      do_reset();
      xfer({8'h06, 32'h0}, n, rx, oe);
      chk($sformatf("R2 wel n=%0d", n), wel_o, (n == 8));
    end

    // R3/R4/R5 unlocked read
    do_reset();
    xfer({8'h83, 16'h0400, 16'h0}, 40, rx, oe);
    chk("R3 unlocked read", rx, rd_exp(1'b0, 1'b1, 40));
    chk("R5 oe while low", oe, 1);
    chk("R5 oe after high", miso_oe_o, 0);

    // R6/R7/R8: cut-off position sweep
    for (int n = 28; n <= 40; n++) begin
      do_reset();
      send_wren();
      xfer({8'h82, 16'h0400, 8'h02, 8'h00}, n, rx, oe);
      chk($sformatf("R6 busy n=%0d", n), busy_o, (n == 32));
      chk($sformatf("R7 wel n=%0d", n), wel_o, (n == 32));
      if (n == 32) begin
        repeat (TW + 20) @(negedge clk);
        chk("R8 locked", locked_o, 1);
        chk("R8 wel cleared", wel_o, 0);
        chk("R8 busy over", busy_o, 0);
      end
    end

    // R11: address/data don't-care sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0]  d;
      logic [15:0] a;
      logic        a10, acc;
      d = 8'(i * 53 + 7);
      a = 16'(i * 4999);
      a10 = (i % 3) != 0;
      a[10] = a10;
      acc = a10 && d[1];
      do_reset();
      send_wren();
      xfer({8'h82, a, d, 8'h00}, 32, rx, oe);
      chk($sformatf("R11 busy a=%0h d=%0h", a, d), busy_o, acc);
      if (acc) begin
        repeat (TW + 20) @(negedge clk);
        chk("R11 locked", locked_o, 1);
      end else begin
        chk("R7 wel dropped", wel_o, 0);
      end
    end

    // R6: no prior write enable
    do_reset();
    xfer({8'h82, 16'h0400, 8'h02, 8'h00}, 32, rx, oe);
    chk("R6 no wren busy", busy_o, 0);

    // R9: traffic during the write cycle
    do_reset();
    send_wren();
    xfer({8'h82, 16'hFFFF, 8'hFF, 8'h00}, 32, rx, oe);
    chk("R6 accepted", busy_o, 1);
    xfer({8'h82, 16'h0400, 8'h02, 8'h00}, 31, rx, oe);
    chk("R9 wel kept while busy", wel_o, 1);
    xfer({8'h83, 16'h0400, 16'h0}, 40, rx, oe);
    chk("R9 read ignored", rx, 40'h0);
    chk("R9 still busy", busy_o, 1);
    repeat (TW) @(negedge clk);
    chk("R8 done", busy_o, 0);
    chk("R8 locked", locked_o, 1);
    chk("R8 wel", wel_o, 0);

    // locked state: R3 repeat, R4 a10=0, R10 sticky
    xfer({8'h83, 16'hFBFF, 16'h0}, 40, rx, oe);
    chk("R4 a10 clear read", rx, rd_exp(1'b1, 1'b0, 40));
    xfer({8'h83, 16'h0400, 16'h0}, 40, rx, oe);
    chk("R3 locked read repeat", rx, rd_exp(1'b1, 1'b1, 40));
    send_wren();
    chk("R2 wel after lock", wel_o, 1);
    xfer({8'h82, 16'h0400, 8'h02, 8'h00}, 32, rx, oe);
    chk("R6 relock rejected", busy_o, 0);
    chk("R7 wel cleared", wel_o, 0);
    chk("R10 locked kept", locked_o, 1);
    xfer({8'h06, 32'h0}, 3, rx, oe);
    chk("R10 locked after traffic", locked_o, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule